// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block decides when a small microcontroller core must take an interrupt from one of two timer-overflow sources, and where the core must jump. Both request flags, both source enables and a global enable live in one 8-bit control byte. The core reads and writes this byte over a simple data-memory bus.

A timer overflow latches the matching request flag. On each edge of the core's sampling phase (the `sample_en` strobe), the block checks every pending request against the enables and the return-stack state. It then issues at most one acknowledge pulse, which carries the vector of the winning source. Taking an interrupt clears the served flag and the global enable in the same step, so nesting stays blocked until software or a RETI turns the enable back on.

Top module: `irq_ctl_top`

## Requirements
- R1: After synchronous reset, every control bit is 0, so a read of the control byte returns 0x00, and `irq_ack` and `wake` are 0.
- R2: The control byte sits at bus address 0x0B. Its layout is: bit 0 global enable, bit 2 timer-0 enable, bit 3 timer-1 enable, bit 5 timer-0 flag, bit 6 timer-1 flag. Bits 1, 4 and 7 always read 0. Writes to any other address change nothing. Read data appears one cycle after `bus_rd`.
- R3: A pulse on `tmr_ovf[i]` sets flag i. The flag stays set until that source is acknowledged or software writes 0 to it.
- R4: An acknowledge is issued only on a cycle with `sample_en` high in which the global enable, the source enable and the source flag are all 1 and `stack_full` is 0. No acknowledge occurs between sampling strobes.
- R5: Timer 0 vectors to 0x08 and timer 1 vectors to 0x0C. When both are eligible, timer 0 wins.
- R6: The acknowledge clears the served flag and the global enable at the same clock edge. A flag that is not served stays set.
- R7: While the global enable is 0, overflows still set their flags, but no acknowledge is issued.
- R8: A `reti_stb` pulse sets the global enable to 1. A `ret_stb` pulse leaves it unchanged.
- R9: When a software write and a hardware overflow hit the same flag in the same cycle, the flag ends up 1.
- R10: `wake` is 1 one cycle after any flag is set while its source enable is 1, and it is 0 when no enabled flag is pending.
- R11: `irq_ack` is a single-cycle pulse, and `irq_vec` is valid while it is high.
- R12: While `stack_full` is 1, pending requests are held and not acknowledged. The first sampling strobe after `stack_full` falls services them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Data-memory address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, 0 when the address does not match |
| tmr_ovf | input | 2 | Overflow pulses, bit i for timer i |
| sample_en | input | 1 | Sampling-phase edge strobe |
| stack_full | input | 1 | Return stack has no free entry |
| ret_stb | input | 1 | Plain return executed |
| reti_stb | input | 1 | Return-from-interrupt executed |
| irq_ack | output | 1 | Vectored call request, one cycle |
| irq_vec | output | 8 | Call target address |
| wake | output | 1 | An enabled request is pending |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a software write to the control byte and a hardware overflow on the same flag. The bench provokes it by driving `bus_wr` and `tmr_ovf` on one cycle, then reads the byte back and expects the flag set. The second pair is the acknowledge and the enable/flag update. A scoreboard queue holds the expected vector for each sampling strobe that should fire, and a monitor pops one entry per `irq_ack` pulse. A readback right after each acknowledge must show the served flag and the global enable both cleared, while the other flag is untouched.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NSRC     = 2;
  localparam int unsigned DW       = 8;
  localparam int unsigned GIE_BIT  = 0;
  localparam int unsigned EN_LSB   = 2;
  localparam int unsigned FLG_LSB  = 5;
  localparam int unsigned SRC_W    = (NSRC > 1) ? $clog2(NSRC) : 1;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] ovf,
  input  logic            take,
  input  logic [NSRC-1:0] take_sel,
  input  logic            reti,
  output logic            gie,
  output logic [NSRC-1:0] en,
  output logic [NSRC-1:0] flg
);
  logic unused_wbits;
  assign unused_wbits = ^wdata;

  // global enable: an acknowledge clears it, RETI sets it, software writes it
  always_ff @(posedge clk) begin
    if (rst)        gie <= 1'b0;
    else if (take)  gie <= 1'b0;
    else if (reti)  gie <= 1'b1;
    else if (wr_en) gie <= wdata[GIE_BIT];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)        en[i] <= 1'b0;
      else if (wr_en) en[i] <= wdata[EN_LSB+i];
    end

    // a hardware set beats both the acknowledge clear and a software write
    always_ff @(posedge clk) begin
      if (rst)                       flg[i] <= 1'b0;
      else if (ovf[i])               flg[i] <= 1'b1;
      else if (take && take_sel[i])  flg[i] <= 1'b0;
      else if (wr_en)                flg[i] <= wdata[FLG_LSB+i];
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_pkg::*;
#(
  parameter logic [DW-1:0] VEC_BASE = 8'h08,
  parameter logic [DW-1:0] VEC_STEP = 8'h04
) (
  input  logic            gie,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] flg,
  input  logic            sample,
  input  logic            stack_full,
  output logic            fire,
  output logic [NSRC-1:0] sel,
  output logic [DW-1:0]   vec
);
  logic [NSRC-1:0] elig;
  assign elig = flg & en;

  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    sel = '0;
    vec = VEC_BASE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
        vec    = VEC_BASE + DW'(VEC_STEP * DW'(i));
      end
    end
  end

  assign fire = sample && gie && !stack_full && (|elig);
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h0B,
  parameter logic [DW-1:0]    VEC_BASE = 8'h08,
  parameter logic [DW-1:0]    VEC_STEP = 8'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NSRC-1:0]   tmr_ovf,
  input  logic              sample_en,
  input  logic              stack_full,
  input  logic              ret_stb,
  input  logic              reti_stb,
  output logic              irq_ack,
  output logic [DW-1:0]     irq_vec,
  output logic              wake
);
  logic            hit;
  logic            gie;
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] flags;
  logic            fire;
  logic [NSRC-1:0] sel;
  logic [DW-1:0]   vec_nx;
  logic [DW-1:0]   image;
  logic            unused_ret;

  // a plain return has no effect on the controller
  assign unused_ret = ret_stb;
  assign hit = (bus_addr == CTL_ADDR);

  irq_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr && hit),
    .wdata    (bus_wdata),
    .ovf      (tmr_ovf),
    .take     (fire),
    .take_sel (sel),
    .reti     (reti_stb),
    .gie      (gie),
    .en       (en),
    .flg      (flags)
  );

  irq_arb #(.VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
    .gie        (gie),
    .en         (en),
    .flg        (flags),
    .sample     (sample_en),
    .stack_full (stack_full),
    .fire       (fire),
    .sel        (sel),
    .vec        (vec_nx)
  );

  always_comb begin
    image          = '0;
    image[GIE_BIT] = gie;
    for (int i = 0; i < NSRC; i++) begin
      image[EN_LSB+i]  = en[i];
      image[FLG_LSB+i] = flags[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ack   <= 1'b0;
      irq_vec   <= '0;
      wake      <= 1'b0;
      bus_rdata <= '0;
    end else begin
      irq_ack   <= fire;
      if (fire) irq_vec <= vec_nx;
      wake      <= |(flags & en);
      bus_rdata <= (bus_rd && hit) ? image : '0;
    end
  end
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk
  import irq_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            ack,
  input logic [DW-1:0]   vec,
  input logic            sample,
  input logic            stack_full,
  input logic            gie,
  input logic [NSRC-1:0] flags,
  input logic [NSRC-1:0] ovf
);
  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst) ack |=> !ack);
  // R4
  ack_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(sample) && $past(gie));
  // R12
  ack_stack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> !$past(stack_full));
  // R6
  ack_gie_clr_chk: assert property (@(posedge clk) disable iff (rst) ack |-> !gie);
  // R5
  ack_vec_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> (vec == 8'h08 || vec == 8'h0C));
  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ovf[0] && !rst) |-> flags[0]);
endmodule

bind irq_ctl_top irq_ctl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ack        (irq_ack),
  .vec        (irq_vec),
  .sample     (sample_en),
  .stack_full (stack_full),
  .gie        (gie),
  .flags      (flags),
  .ovf        (tmr_ovf)
);

// File: tb/test_irq_ctl_top.sv
`timescale 1ns/1ps
module test_irq_ctl_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h0B;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] tmr_ovf = 2'b00;
  logic       sample_en = 1'b0, stack_full = 1'b0;
  logic       ret_stb = 1'b0, reti_stb = 1'b0;
  logic       irq_ack, wake;
  logic [7:0] irq_vec;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] expq[$];
  logic prev_ack = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_ctl_top i_irq_ctl_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf(tmr_ovf),
    .sample_en(sample_en), .stack_full(stack_full), .ret_stb(ret_stb),
    .reti_stb(reti_stb), .irq_ack(irq_ack), .irq_vec(irq_vec), .wake(wake)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor: each acknowledge pops one expected vector
  always @(negedge clk) begin
    if (!rst && irq_ack) begin
      if (expq.size() == 0) chk("R4 unexpected ack", 8'h01, 8'h00);
      else chk("R5 vector", irq_vec, expq.pop_front());
    end
    if (!rst && prev_ack) chk("R11 pulse width", {7'd0, irq_ack}, 8'h00);
    prev_ack = irq_ack;
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h0B;
  endtask

  task automatic rd(string req, logic [7:0] exp);
    bus_addr = 8'h0B; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic ovf(logic [1:0] m);
    tmr_ovf = m;
    @(negedge clk);
    tmr_ovf = 2'b00;
  endtask

  task automatic smp();
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic strobe(bit is_reti);
    if (is_reti) reti_stb = 1'b1; else ret_stb = 1'b1;
    @(negedge clk);
    reti_stb = 1'b0; ret_stb = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ack", {7'd0, irq_ack}, 8'h00);
    chk("R1 wake", {7'd0, wake}, 8'h00);
    rd("R1 control", 8'h00);

    // R2 layout, unused bits, address decode
    wr(8'h0B, 8'hFF);
    rd("R2 unused bits", 8'h6D);
    wr(8'h0A, 8'h00);
    rd("R2 other address", 8'h6D);
    wr(8'h0B, 8'h00);
    rd("R3 software clear", 8'h00);

    // R3 flag holds
    ovf(2'b01);
    rd("R3 set", 8'h20);
    repeat (4) @(negedge clk);
    rd("R3 hold", 8'h20);
    wr(8'h0B, 8'h00);

    // R7 global enable off
    wr(8'h0B, 8'h0C);
    ovf(2'b11);
    @(negedge clk);
    chk("R10 wake high", {7'd0, wake}, 8'h01);
    smp();
    rd("R7 flags kept, no ack", 8'h6C);

    // R5 priority, R6 atomic clear
    wr(8'h0B, 8'h6D);
    expq.push_back(8'h08);
    smp();
    chk("R5 delivered", 8'(expq.size()), 8'h00);
    rd("R6 cleared flag and enable", 8'h4C);
    strobe(1'b0);
    rd("R8 RET no effect", 8'h4C);
    strobe(1'b1);
    rd("R8 RETI sets enable", 8'h4D);
    expq.push_back(8'h0C);
    smp();
    rd("R6 second source", 8'h0C);

    // R12 stack full holds off
    ovf(2'b01);
    strobe(1'b1);
    rd("R12 pending", 8'h2D);
    stack_full = 1'b1;
    smp();
    smp();
    rd("R12 held", 8'h2D);
    stack_full = 1'b0;
    expq.push_back(8'h08);
    smp();
    chk("R12 released", 8'(expq.size()), 8'h00);
    rd("R12 after ack", 8'h0C);

    // R4 source enable gates
    wr(8'h0B, 8'h01);
    ovf(2'b10);
    smp();
    rd("R4 source disabled", 8'h41);
    @(negedge clk);
    chk("R10 wake low", {7'd0, wake}, 8'h00);

    // R9 write and overflow in the same cycle
    bus_addr = 8'h0B; bus_wdata = 8'h00; bus_wr = 1'b1; tmr_ovf = 2'b01;
    @(negedge clk);
    bus_wr = 1'b0; tmr_ovf = 2'b00;
    rd("R9 hardware wins", 8'h20);

    // R4 no ack without a sampling strobe
    wr(8'h0B, 8'h25);
    repeat (5) @(negedge clk);
    rd("R4 waits for sample", 8'h25);
    expq.push_back(8'h08);
    smp();
    rd("R4 serviced on sample", 8'h04);

    chk("R5 queue drained", 8'(expq.size()), 8'h00);
    finish_up();
  end
endmodule